// File: doc/BRIEF.md
# Processor Power Mode Controller

This block steps a processor core through its low-power states and produces the clock enables for each clock domain of the core: instruction fetch, the functional units, the time base and decrementer, the test port, and the snoop logic. Software asks for nap or sleep with a one-cycle request. The controller then raises a quiesce request and waits for the system's acknowledge before it gates any clock. While the core naps, a snoop indication from the system moves it into a short doze state. In doze the snoop logic runs and the quiesce request is dropped. When the snoop ends, the controller asks for quiesce again and goes back to nap.

From sleep, the system may stop the PLL. The controller then enters deep sleep and switches the PLL enable off. A wake event in deep sleep turns the PLL back on and holds the core in a relock state. The core leaves relock only after the PLL reports lock and a minimum number of cycles has passed. A software divide-by-two select for the core clock is taken only while the core runs at full power. It is registered, so it changes only on a clock edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is at full power: every domain enable is 1, `qreq` is 0, `pll_en` is 1 and `clk_div2` is 0.
- R2: At full power, `req_valid` with `req_mode`=1 (nap) or 2 (sleep) sets `qreq` to 1 from the next cycle. All domain enables stay 1 until the cycle after `qack` is seen high, and the low-power state is entered in that cycle.
- R3: In nap, `fetch_en`, `fu_en` and `snoop_en` are 0, `tb_en` and `jtag_en` are 1, and `qreq` and `pll_en` are 1.
- R4: In nap, a high `snoop_req` (with no wake) moves the controller to doze in the next cycle. Doze has `snoop_en`, `tb_en` and `jtag_en` at 1, `fetch_en` and `fu_en` at 0, and `qreq` at 0. When `snoop_req` goes low, `qreq` is 1 again from the next cycle, and nap resumes in the cycle after `qack` is seen.
- R5: In sleep, every domain enable is 0, while `qreq` and `pll_en` are 1.
- R6: In sleep, a high `pll_stop_req` (with no wake) enters deep sleep in the next cycle. Deep sleep has `pll_en` at 0 and every domain enable at 0. `pll_stop_req` has no effect in any other state.
- R7: A wake in deep sleep enters relock in the next cycle. Relock has `pll_en` at 1 and every domain enable at 0. Full power returns in the cycle after one in which `pll_lock` is high and the controller has spent at least RELOCK_WAIT cycles in relock, counting that cycle.
- R8: `wake` in nap, doze or sleep returns the controller to full power in the next cycle. It takes priority over `snoop_req` and `pll_stop_req`.
- R9: `clk_div2` takes the value of `dfs_req` one cycle later, and only when the controller was at full power in the sampling cycle. Otherwise it holds its value.
- R10: `req_valid` is ignored outside full power, and `req_mode` values 0 and 3 are ignored at full power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle software mode request strobe |
| req_mode | input | 2 | Requested mode: 1 nap, 2 sleep |
| qack | input | 1 | System quiesce acknowledge |
| snoop_req | input | 1 | System needs the core to snoop |
| wake | input | 1 | Wake event |
| pll_stop_req | input | 1 | System stops the PLL |
| pll_lock | input | 1 | PLL lock indication |
| dfs_req | input | 1 | Software divide-by-two request level |
| fetch_en | output | 1 | Instruction fetch clock enable |
| fu_en | output | 1 | Functional unit clock enable |
| tb_en | output | 1 | Time base / decrementer clock enable |
| jtag_en | output | 1 | Test port clock enable |
| snoop_en | output | 1 | Snoop logic clock enable |
| qreq | output | 1 | Quiesce request to system |
| pll_en | output | 1 | PLL enable |
| clk_div2 | output | 1 | Core clock divide-by-two select |

## Verification
Directed sequences cover three kinds of case. The first is a quiesce acknowledge held back for several cycles, which tells a state change gated on `qack` from one made on the request alone. The second is a doze round trip with a late acknowledge. The third is a wake that arrives together with a snoop or a PLL stop, which shows which input wins. Relock is tried with lock asserted early and with lock asserted late, so the minimum wait can be told apart from the lock condition. A long seeded random run then mixes all inputs at rates that reach every state repeatedly. Each cycle is compared with a bench model of the transitions; the runs include divide requests outside full power and requests that must be ignored.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      PS_RUN, PS_ENT_NAP, PS_ENT_SLP, PS_NAP,
      PS_DOZE, PS_SLEEP, PS_DEEP, PS_RELOCK
   } pstate_t;

   localparam int MODE_W = 2;
   localparam logic [MODE_W-1:0] REQ_NAP   = 2'd1;
   localparam logic [MODE_W-1:0] REQ_SLEEP = 2'd2;

   typedef struct packed {
      logic fetch;
      logic fu;
      logic tbase;
      logic jtag;
      logic snoop;
      logic qreq;
      logic pll;
   } dom_en_t;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int RELOCK_WAIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              qack,
   input  logic              snoop_req,
   input  logic              wake,
   input  logic              pll_stop_req,
   input  logic              pll_lock,
   output pstate_t           state
);
   localparam int CNT_W = (RELOCK_WAIT < 2) ? 1 : $clog2(RELOCK_WAIT + 1);

   initial begin
      assert (RELOCK_WAIT >= 0) else $error("RELOCK_WAIT must not be negative");
      assert (CNT_W <= 31) else $error("relock counter too wide");
   end

   pstate_t state_nx;
   logic    relock_done;

   generate
      if (RELOCK_WAIT <= 1) begin : g_no_wait
         assign relock_done = 1'b1;
      end else begin : g_wait
         logic [CNT_W-1:0] relock_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || state != PS_RELOCK)
               relock_cnt <= '0;
            else if (!relock_done)
               relock_cnt <= relock_cnt + 1'b1;
         end
         assign relock_done = (relock_cnt >= CNT_W'(RELOCK_WAIT - 1));
      end
   endgenerate

   always_comb begin
      state_nx = state;
      unique case (state)
         PS_RUN: begin
            if (req_valid && req_mode == REQ_NAP)        state_nx = PS_ENT_NAP;
            else if (req_valid && req_mode == REQ_SLEEP) state_nx = PS_ENT_SLP;
         end
         PS_ENT_NAP: if (qack) state_nx = PS_NAP;
         PS_ENT_SLP: if (qack) state_nx = PS_SLEEP;
         PS_NAP: begin
            if (wake)           state_nx = PS_RUN;
            else if (snoop_req) state_nx = PS_DOZE;
         end
         PS_DOZE: begin
            if (wake)            state_nx = PS_RUN;
            else if (!snoop_req) state_nx = PS_ENT_NAP;
         end
         PS_SLEEP: begin
            if (wake)              state_nx = PS_RUN;
            else if (pll_stop_req) state_nx = PS_DEEP;
         end
         PS_DEEP:   if (wake) state_nx = PS_RELOCK;
         PS_RELOCK: if (pll_lock && relock_done) state_nx = PS_RUN;
         default:   state_nx = PS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= PS_RUN;
      else        state <= state_nx;
   end

   assert_qack_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_ENT_NAP && !qack) |=> state == PS_ENT_NAP);
   assert_deep_from_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DEEP && $past(state) != PS_DEEP) |-> $past(state) == PS_SLEEP);
   assert_relock_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RELOCK && !pll_lock) |=> state == PS_RELOCK);
   assert_wake_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PS_NAP || state == PS_DOZE || state == PS_SLEEP) && wake) |=> state == PS_RUN);
endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
   import pmc_pkg::*;
(
   input  pstate_t state,
   output dom_en_t en
);
   always_comb begin
      en = '{fetch: 1'b1, fu: 1'b1, tbase: 1'b1, jtag: 1'b1,
             snoop: 1'b1, qreq: 1'b0, pll: 1'b1};
      unique case (state)
         PS_RUN: ;
         PS_ENT_NAP, PS_ENT_SLP: en.qreq = 1'b1;
         PS_NAP: begin
            en.fetch = 1'b0; en.fu = 1'b0; en.snoop = 1'b0; en.qreq = 1'b1;
         end
         PS_DOZE: begin
            en.fetch = 1'b0; en.fu = 1'b0;
         end
         PS_SLEEP, PS_RELOCK: begin
            en = '{fetch: 1'b0, fu: 1'b0, tbase: 1'b0, jtag: 1'b0,
                   snoop: 1'b0, qreq: 1'b1, pll: 1'b1};
         end
         PS_DEEP: begin
            en = '{fetch: 1'b0, fu: 1'b0, tbase: 1'b0, jtag: 1'b0,
                   snoop: 1'b0, qreq: 1'b1, pll: 1'b0};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pmc_dfs.sv
module pmc_dfs
   import pmc_pkg::*;
#(
   parameter bit DFS_EN = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pstate_t state,
   input  logic    dfs_req,
   output logic    clk_div2
);
   generate
      if (DFS_EN) begin : g_dfs
         always_ff @(posedge clk) begin
            if (!rst_n)                clk_div2 <= 1'b0;
            else if (state == PS_RUN) clk_div2 <= dfs_req;
         end

         assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (state != PS_RUN) |=> $stable(clk_div2));
      end else begin : g_no_dfs
         assign clk_div2 = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int RELOCK_WAIT = 4,
   parameter bit DFS_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_mode,
   input  logic       qack,
   input  logic       snoop_req,
   input  logic       wake,
   input  logic       pll_stop_req,
   input  logic       pll_lock,
   input  logic       dfs_req,
   output logic       fetch_en,
   output logic       fu_en,
   output logic       tb_en,
   output logic       jtag_en,
   output logic       snoop_en,
   output logic       qreq,
   output logic       pll_en,
   output logic       clk_div2
);
   pstate_t state;
   dom_en_t en;

   pmc_seq #(.RELOCK_WAIT(RELOCK_WAIT)) u_seq (
      .clk, .rst_n, .req_valid, .req_mode, .qack, .snoop_req,
      .wake, .pll_stop_req, .pll_lock, .state
   );

   pmc_decode u_decode (.state, .en);

   pmc_dfs #(.DFS_EN(DFS_EN)) u_dfs (
      .clk, .rst_n, .state, .dfs_req, .clk_div2
   );

   assign fetch_en = en.fetch;
   assign fu_en    = en.fu;
   assign tb_en    = en.tbase;
   assign jtag_en  = en.jtag;
   assign snoop_en = en.snoop;
   assign qreq     = en.qreq;
   assign pll_en   = en.pll;

   assert_pll_off_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> !(fetch_en || fu_en || tb_en || jtag_en || snoop_en));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
   localparam int WAIT = 4;
   localparam int M_RUN = 0, M_EN = 1, M_ES = 2, M_NAP = 3, M_DOZE = 4,
                  M_SLP = 5, M_DEEP = 6, M_REL = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, qack = 0, snoop_req = 0, wake = 0;
   logic pll_stop_req = 0, pll_lock = 0, dfs_req = 0;
   logic [1:0] req_mode = '0;
   logic fetch_en, fu_en, tb_en, jtag_en, snoop_en, qreq, pll_en, clk_div2;

   int checks = 0, fails = 0;
   int cur = M_RUN, pend = M_RUN, prev = M_RUN;
   int cnt = 0, pcnt = 0;
   logic cdiv = 0, pdiv = 0;
   logic prev_ign = 0;

   always #4 clk = ~clk;

   pwr_mode_ctrl u_pwr_mode_ctrl (
      .clk, .rst_n, .req_valid, .req_mode, .qack, .snoop_req, .wake,
      .pll_stop_req, .pll_lock, .dfs_req, .fetch_en, .fu_en, .tb_en,
      .jtag_en, .snoop_en, .qreq, .pll_en, .clk_div2
   );

   // {fetch, fu, tb, jtag, snoop, qreq, pll}
   function automatic logic [6:0] exp_out(int s);
      case (s)
         M_RUN:         return 7'b1111101;
         M_EN, M_ES:    return 7'b1111111;
         M_NAP:         return 7'b0011011;   // R3
         M_DOZE:        return 7'b0011101;   // R4
         M_SLP, M_REL:  return 7'b0000011;   // R5 / R7
         default:       return 7'b0000010;   // R6 deep sleep
      endcase
   endfunction

   function automatic string tag(int s, int p, logic ign);
      if (s == M_RUN && (p == M_NAP || p == M_DOZE || p == M_SLP)) return "R8";
      if (s == M_RUN && ign) return "R10";
      case (s)
         M_RUN:      return "R1";
         M_EN, M_ES: return "R2";
         M_NAP:      return "R3";
         M_DOZE:     return "R4";
         M_SLP:      return "R5";
         M_DEEP:     return "R6";
         default:    return "R7";
      endcase
   endfunction

   function automatic int next_st(int s, int c, logic v, logic [1:0] m, logic qa,
                                  logic sn, logic wk, logic st, logic lk);
      case (s)
         M_RUN:  return (v && m == 2'd1) ? M_EN : (v && m == 2'd2) ? M_ES : M_RUN;
         M_EN:   return qa ? M_NAP : M_EN;
         M_ES:   return qa ? M_SLP : M_ES;
         M_NAP:  return wk ? M_RUN : sn ? M_DOZE : M_NAP;
         M_DOZE: return wk ? M_RUN : !sn ? M_EN : M_DOZE;
         M_SLP:  return wk ? M_RUN : st ? M_DEEP : M_SLP;
         M_DEEP: return wk ? M_REL : M_DEEP;
         default: return (lk && c >= WAIT - 1) ? M_RUN : M_REL;
      endcase
   endfunction

   task automatic step(logic v, logic [1:0] m, logic qa, logic sn, logic wk,
                       logic st, logic lk, logic df);
      logic [6:0] act;
      @(negedge clk);
      prev = cur; cur = pend; cnt = pcnt; cdiv = pdiv;
      act = {fetch_en, fu_en, tb_en, jtag_en, snoop_en, qreq, pll_en};
      checks++;
      if (act !== exp_out(cur)) begin
         fails++;
         $display("FAIL %s: outputs %b expected %b", tag(cur, prev, prev_ign), act, exp_out(cur));
      end
      checks++;
      if (clk_div2 !== cdiv) begin
         fails++;
         $display("FAIL R9: clk_div2 %b expected %b", clk_div2, cdiv);
      end
      req_valid = v; req_mode = m; qack = qa; snoop_req = sn; wake = wk;
      pll_stop_req = st; pll_lock = lk; dfs_req = df;
      prev_ign = v && (cur != M_RUN || m == 2'd0 || m == 2'd3);
      pend = next_st(cur, cnt, v, m, qa, sn, wk, st, lk);
      pcnt = (cur == M_REL && pend == M_REL) ? cnt + 1 : 0;
      pdiv = (cur == M_RUN) ? df : cdiv;
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, then R9 divide at full power
      step(0,0,0,0,0,0,0,1);
      step(0,0,0,0,0,0,0,0);
      step(0,0,0,0,0,0,0,1);
      // R2 nap entry with late acknowledge
      step(1,1,0,0,0,0,0,1);
      step(0,0,0,0,0,0,0,0);
      step(0,0,0,0,0,0,0,0);
      step(0,0,1,0,0,0,0,0);
      // R3 nap, R6 stop ignored in nap, R9 hold
      step(0,0,0,0,0,1,0,0);
      // R4 doze round trip
      step(0,0,0,1,0,0,0,0);
      step(0,0,0,1,0,0,0,0);
      step(0,0,0,0,0,0,0,0);
      step(0,0,0,0,0,0,0,0);
      step(0,0,1,0,0,0,0,0);
      // R8 wake beats snoop
      step(0,0,0,1,1,0,0,0);
      // R10 ignored mode
      step(1,3,1,0,0,0,0,0);
      step(1,0,1,0,0,0,0,0);
      // R5 sleep, R8 wake beats stop
      step(1,2,1,0,0,0,0,0);
      step(0,0,1,0,0,0,0,0);
      step(0,0,0,0,1,1,0,1);
      // sleep again, then R6 deep, R7 relock with early lock
      step(1,2,1,0,0,0,0,1);
      step(0,0,1,0,0,0,0,0);
      step(0,0,0,0,0,1,1,0);
      step(1,1,0,0,0,0,1,0);
      step(0,0,0,0,1,0,0,0);
      step(0,0,0,0,0,0,1,0);
      step(0,0,0,0,0,0,1,0);
      step(0,0,0,0,0,0,0,0);
      step(0,0,0,0,0,0,0,0);
      step(0,0,0,0,0,0,1,0);
      step(0,0,0,0,0,0,0,0);
      // seeded random mix
      for (int i = 0; i < 6000; i++) begin
         step(($urandom % 6) == 0, 2'($urandom % 4), ($urandom % 3) == 0,
              ($urandom % 3) == 0, ($urandom % 14) == 0, ($urandom % 4) == 0,
              ($urandom % 3) == 0, 1'($urandom % 2));
      end
      step(0,0,0,0,0,0,0,0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule